// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block runs one asynchronous external-memory access at a time. A host hands it a request pulse with address, write data, direction and a count of extra page beats. The block then drives four active-low strobes: chip select, address valid, output enable and write enable. Each strobe's active window is set by static configuration inputs, counted in ticks from the start of the access. A tick lasts one to four functional clocks, as a 2-bit divider field selects.

Read accesses sample the memory data bus at a programmable access tick and return the data with a one-clock valid pulse. In page mode, further beats follow at a fixed tick spacing, each at the next address. A one-clock acknowledge marks the end of every access. Reads and writes share the strobe assertion ticks. Chip select and address valid each have separate release ticks for reads and for writes, and the total access length is also set separately for each direction.

Top module: `async_strobe_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, all four strobes are high, `ack` and `rd_valid` are low and `mem_wdata_oe` is low.
- R2: One tick lasts `cfg_div`+1 clocks. Tick 0 is the first clock after the edge that accepts `req`, and each tick begins a new group of `cfg_div`+1 clocks.
- R3: `mem_cs_n` is low during ticks t with `cfg_cs_on` <= t < off. Off is `cfg_cs_rd_off` for reads and `cfg_cs_wr_off` for writes.
- R4: `mem_adv_n` follows the same rule as R3, using `cfg_adv_on`, `cfg_adv_rd_off` and `cfg_adv_wr_off`.
- R5: `mem_oe_n` is low only during reads, for ticks `cfg_oe_on` <= t < `cfg_oe_off`. `mem_we_n` is low only during writes, for ticks `cfg_we_on` <= t < `cfg_we_off`. The two strobes are never low together.
- R6: When a strobe's off tick is not greater than its on tick, that strobe stays high for the whole access.
- R7: An access with total length L ticks is busy for L*(`cfg_div`+1)+1 clocks. `ack` is high for exactly the one clock after that. L is `cfg_wr_len` for writes and `cfg_rd_len` for single reads.
- R8: A read samples `mem_rdata` in the first clock of tick `cfg_access`. The sampled value appears on `rd_data` with `rd_valid` high for one clock. No sample is taken on writes.
- R9: A read with `req_beats`=n makes n+1 samples. Beat k is sampled at tick `cfg_access`+k*g, with `mem_addr` = base+k. The read length becomes `cfg_rd_len`+n*g. Here g is `cfg_page_gap`, or 1 when that field is 0.
- R10: A `req` pulse during a busy access is ignored. The access in progress keeps its address and timing, and no second access starts.
- R11: During a write, `mem_addr` and `mem_wdata` hold the request values and `mem_wdata_oe` is high. `req_beats` has no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request pulse, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start address |
| req_wdata | input | DW | Write data |
| req_beats | input | BLW | Extra page beats for reads |
| ack | output | 1 | One-clock end-of-access pulse |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Sampled read data |
| cfg_div | input | 2 | Clocks per tick minus one |
| cfg_cs_on | input | 4 | Chip-select assert tick |
| cfg_cs_rd_off | input | 5 | Chip-select release tick, reads |
| cfg_cs_wr_off | input | 5 | Chip-select release tick, writes |
| cfg_adv_on | input | 4 | Address-valid assert tick |
| cfg_adv_rd_off | input | 5 | Address-valid release tick, reads |
| cfg_adv_wr_off | input | 5 | Address-valid release tick, writes |
| cfg_oe_on | input | 4 | Output-enable assert tick |
| cfg_oe_off | input | 5 | Output-enable release tick |
| cfg_we_on | input | 4 | Write-enable assert tick |
| cfg_we_off | input | 5 | Write-enable release tick |
| cfg_rd_len | input | 5 | Read access length in ticks |
| cfg_wr_len | input | 5 | Write access length in ticks |
| cfg_access | input | 5 | Read sample tick |
| cfg_page_gap | input | 4 | Ticks between page beats |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_wdata_oe | output | 1 | Drive enable for write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The hardest situation to reach is a page-burst read in which sample points, address steps and the extended end of the access all interact with a divider above 1. The bench reaches it with multi-beat reads at a nonzero divider, and with a zero gap field to exercise the clamp to 1. A clock-by-clock reference model predicts every strobe level, the address and the acknowledge clock. The ignored-request case is provoked by pulsing `req` with a different address in the middle of a read, then checking that the address, the end time and the idle clocks that follow are unchanged.

// File: rtl/async_strobe_seq.sv
module async_strobe_seq #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BLW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           req_wr,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BLW-1:0] req_beats,
  output logic           ack,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  input  logic [1:0]     cfg_div,
  input  logic [3:0]     cfg_cs_on,
  input  logic [4:0]     cfg_cs_rd_off,
  input  logic [4:0]     cfg_cs_wr_off,
  input  logic [3:0]     cfg_adv_on,
  input  logic [4:0]     cfg_adv_rd_off,
  input  logic [4:0]     cfg_adv_wr_off,
  input  logic [3:0]     cfg_oe_on,
  input  logic [4:0]     cfg_oe_off,
  input  logic [3:0]     cfg_we_on,
  input  logic [4:0]     cfg_we_off,
  input  logic [4:0]     cfg_rd_len,
  input  logic [4:0]     cfg_wr_len,
  input  logic [4:0]     cfg_access,
  input  logic [3:0]     cfg_page_gap,
  output logic           mem_cs_n,
  output logic           mem_adv_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_wdata_oe,
  input  logic [DW-1:0]  mem_rdata
);

  localparam int TW = $clog2(32 + ((1 << BLW) - 1) * 16);
  localparam int LW = BLW + 1;

  logic          busy, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] tick, total, next_s;
  logic [1:0]    dc;
  logic [LW-1:0] left;

  function automatic logic in_win(input logic [TW-1:0] t, input logic [3:0] on, input logic [4:0] off);
    return (t >= TW'(on)) && (t < TW'(off));
  endfunction

  wire [3:0]    gap_eff  = (cfg_page_gap == 4'd0) ? 4'd1 : cfg_page_gap;
  wire          tick_beg = (dc == 2'd0);
  wire          smp      = busy && !wr_q && (left != '0) && tick_beg && (tick == next_s);
  wire          done     = busy && tick_beg && (tick == total);
  wire [TW-1:0] rd_total = TW'(cfg_rd_len) + TW'(req_beats) * TW'(gap_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      tick     <= '0;
      total    <= '0;
      next_s   <= '0;
      dc       <= '0;
      left     <= '0;
      ack      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      ack      <= 1'b0;
      rd_valid <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy    <= 1'b1;
          wr_q    <= req_wr;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          tick    <= '0;
          dc      <= '0;
          total   <= req_wr ? TW'(cfg_wr_len) : rd_total;
          next_s  <= TW'(cfg_access);
          left    <= req_wr ? '0 : LW'(req_beats) + LW'(1);
        end
      end else begin
        if (done) begin
          busy <= 1'b0;
          ack  <= 1'b1;
        end else if (dc == cfg_div) begin
          dc   <= '0;
          tick <= tick + TW'(1);
        end else begin
          dc <= dc + 2'd1;
        end
        if (smp) begin
          rd_data  <= mem_rdata;
          rd_valid <= 1'b1;
          left     <= left - LW'(1);
          next_s   <= next_s + TW'(gap_eff);
          if (left > LW'(1)) addr_q <= addr_q + AW'(1);
        end
      end
    end
  end

  assign mem_cs_n     = !(busy && in_win(tick, cfg_cs_on, wr_q ? cfg_cs_wr_off : cfg_cs_rd_off));
  assign mem_adv_n    = !(busy && in_win(tick, cfg_adv_on, wr_q ? cfg_adv_wr_off : cfg_adv_rd_off));
  assign mem_oe_n     = !(busy && !wr_q && in_win(tick, cfg_oe_on, cfg_oe_off));
  assign mem_we_n     = !(busy && wr_q && in_win(tick, cfg_we_on, cfg_we_off));
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_wdata_oe = busy && wr_q;

endmodule

// File: rtl/async_strobe_seq_chk.sv
module async_strobe_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wr_q,
  input logic          ack,
  input logic          rd_valid,
  input logic          mem_cs_n,
  input logic          mem_adv_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    cfg_cs_on,
  input logic [4:0]    cfg_cs_rd_off
);

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R7
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!busy && $past(busy)));

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R6
  cs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_q && (cfg_cs_rd_off <= {1'b0, cfg_cs_on})) |-> mem_cs_n);

  // R11
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q && $past(busy)) |-> $stable(mem_addr));

  // R8
  rvalid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(busy) && !wr_q));

endmodule

bind async_strobe_seq async_strobe_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_q(wr_q), .ack(ack), .rd_valid(rd_valid),
  .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .cfg_cs_on(cfg_cs_on), .cfg_cs_rd_off(cfg_cs_rd_off)
);

// File: tb/async_strobe_seq_tb.sv
module async_strobe_seq_tb;
  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic [2:0] req_beats = 0;
  logic ack, rd_valid, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_wdata_oe;
  logic [15:0] rd_data, mem_addr, mem_wdata, mem_rdata;
  logic [1:0] cfg_div = 0;
  logic [3:0] cfg_cs_on = 0, cfg_adv_on = 0, cfg_oe_on = 0, cfg_we_on = 0, cfg_page_gap = 0;
  logic [4:0] cfg_cs_rd_off = 0, cfg_cs_wr_off = 0, cfg_adv_rd_off = 0, cfg_adv_wr_off = 0;
  logic [4:0] cfg_oe_off = 0, cfg_we_off = 0, cfg_rd_len = 0, cfg_wr_len = 0, cfg_access = 0;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    return a * 16'd3 + 16'h1234;
  endfunction
  assign mem_rdata = mem_oe_n ? 16'h0000 : mem_fn(mem_addr);

  async_strobe_seq u_dut (.*);

  task automatic check(input bit ok, input string req_tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(0, "R8", "unexpected rd_valid", rd_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R8/R9", "read data", rd_data, e);
      end
    end
  end

  function automatic bit win(input int t, input int on, input int off);
    return t >= on && t < off;
  endfunction

  task automatic set_cfg(input int div, input int cson, input int csr, input int csw,
                         input int advon, input int advr, input int advw,
                         input int oeon, input int oeoff, input int weon, input int weoff,
                         input int rl, input int wl, input int acc, input int gap);
    cfg_div = 2'(div); cfg_cs_on = 4'(cson); cfg_cs_rd_off = 5'(csr); cfg_cs_wr_off = 5'(csw);
    cfg_adv_on = 4'(advon); cfg_adv_rd_off = 5'(advr); cfg_adv_wr_off = 5'(advw);
    cfg_oe_on = 4'(oeon); cfg_oe_off = 5'(oeoff); cfg_we_on = 4'(weon); cfg_we_off = 5'(weoff);
    cfg_rd_len = 5'(rl); cfg_wr_len = 5'(wl); cfg_access = 5'(acc); cfg_page_gap = 4'(gap);
  endtask

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                      input int beats, input bit poke, input string tag);
    int d, g, nb, total, bad_s, bad_a;
    d = int'(cfg_div) + 1;
    g = (cfg_page_gap == 0) ? 1 : int'(cfg_page_gap);
    nb = wr ? 1 : beats + 1;
    total = wr ? int'(cfg_wr_len) : int'(cfg_rd_len) + beats * g;
    if (!wr)
      for (int k = 0; k < nb; k++) begin
        int s;
        s = int'(cfg_access) + k * g;
        if (s <= total)
          exp_q.push_back(win(s, cfg_oe_on, cfg_oe_off) ? mem_fn(a + 16'(k)) : 16'h0000);
      end
    @(negedge clk);
    req = 1; req_wr = wr; req_addr = a; req_wdata = wd; req_beats = 3'(beats);
    @(posedge clk); #1;
    req = 0; req_addr = 16'hdead;
    bad_s = 0; bad_a = 0;
    for (int c = 0; c <= total * d + 1; c++) begin
      int t;
      bit bz;
      logic ecs, eadv, eoe, ewe;
      logic [15:0] eaddr;
      @(negedge clk);
      t = c / d;
      bz = (c <= total * d);
      ecs  = !(bz && win(t, cfg_cs_on, wr ? cfg_cs_wr_off : cfg_cs_rd_off));
      eadv = !(bz && win(t, cfg_adv_on, wr ? cfg_adv_wr_off : cfg_adv_rd_off));
      eoe  = !(bz && !wr && win(t, cfg_oe_on, cfg_oe_off));
      ewe  = !(bz && wr && win(t, cfg_we_on, cfg_we_off));
      eaddr = a;
      for (int k = 0; k < nb - 1; k++)
        if ((int'(cfg_access) + k * g) * d < c) eaddr = eaddr + 16'd1;
      if ({mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n} != {ecs, eadv, eoe, ewe}) begin
        if (bad_s == 0)
          $display("FAIL %s strobes at clock %0d: actual=%b expected=%b", tag, c,
                   {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n}, {ecs, eadv, eoe, ewe});
        bad_s++;
      end
      if (bz && (mem_addr != eaddr || mem_wdata_oe != wr || (wr && mem_wdata != wd))) begin
        if (bad_a == 0)
          $display("FAIL %s bus at clock %0d: actual addr=%0h oe=%b expected addr=%0h oe=%b",
                   tag, c, mem_addr, mem_wdata_oe, eaddr, wr);
        bad_a++;
      end
      if (ack != (c == total * d + 1)) begin
        check(0, tag, "ack timing", c, total * d + 1);
      end
      if (poke && c == 1) begin req = 1; req_addr = 16'hbeef; end
      if (poke && c == 2) req = 0;
    end
    checks += 3;
    if (bad_s != 0) errors++;
    if (bad_a != 0) errors++;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && !ack && !mem_wdata_oe)) begin
        bad_s = -1;
      end
    end
    if (bad_s == -1) begin
      errors++;
      $display("FAIL R1/R10 %s not idle after ack: actual=%b expected=1111", tag,
               {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n});
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    check(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check({mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n} == 4'b1111 && !ack && !rd_valid && !mem_wdata_oe,
          "R1", "reset outputs", {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n}, 4'hf);
    rst_n = 1;
    // R2 R3 R4 R5 R8 single read, divide by 1
    set_cfg(0, 1,9,7, 0,3,2, 2,8, 3,6, 10,8, 6, 2);
    xfer(0, 16'h0100, 16'h0, 0, 0, "R3/R4/R5/R8 read div1");
    // R11 R5 write, divide by 1
    xfer(1, 16'h0200, 16'hc0de, 0, 0, "R11/R5 write div1");
    // R2 R7 read, divide by 4
    set_cfg(3, 2,7,9, 1,4,5, 3,7, 2,8, 8,11, 5, 3);
    xfer(0, 16'h0300, 16'h0, 0, 0, "R2/R7 read div4");
    // R2 R7 write, divide by 3
    set_cfg(2, 0,5,6, 0,2,3, 1,4, 1,5, 6,7, 3, 1);
    xfer(1, 16'h0400, 16'h1357, 0, 0, "R2/R7 write div3");
    // R6 off not above on: cs and oe stay high on read, we stays high on write
    set_cfg(1, 5,5,3, 2,1,6, 6,4, 4,4, 9,9, 5, 2);
    xfer(0, 16'h0500, 16'h0, 0, 0, "R6 empty windows read");
    xfer(1, 16'h0600, 16'h2468, 0, 0, "R6 empty windows write");
    // R9 page burst, divide by 2
    set_cfg(1, 0,20,6, 0,2,2, 1,20, 1,4, 6,8, 4, 2);
    xfer(0, 16'h0700, 16'h0, 3, 0, "R9 burst gap2");
    // R9 zero gap acts as 1
    set_cfg(0, 0,12,6, 0,2,2, 1,12, 1,4, 5,8, 3, 0);
    xfer(0, 16'h0800, 16'h0, 2, 0, "R9 burst gap0");
    // R11 beats ignored on write
    xfer(1, 16'h0900, 16'h55aa, 3, 0, "R11 write ignores beats");
    // R10 req during busy ignored
    set_cfg(1, 1,9,7, 0,3,2, 2,8, 3,6, 10,8, 6, 2);
    xfer(0, 16'h0a00, 16'h0, 0, 1, "R10 req while busy");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "all expected reads delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule